// File: doc/BRIEF.md
# Alarm Time Setting Counters

This block holds an alarm time as six BCD digits (hours, minutes and seconds, each a tens digit and a ones digit) and lets the user set that time by hand. A set button input, `set_up`, is brought into the block clock domain by a short register chain. Each rising edge of the button becomes a single one-cycle step. On that step, every field whose select is high advances by one count, provided the alarm-mode input is also high.

The three fields are independent. Seconds and minutes run 00 to 59 and wrap to 00. Hours run 00 to 23 and wrap to 00. A wrap in one field never moves another field, so the user can set any digit pair without disturbing the rest. Comparison with the running clock, display scanning and alarm sounding are handled by neighbouring blocks that read the six digit outputs.

All control pins are plain levels. The block has no streaming data interface, so it has no valid/ready handshake and no back-pressure.

Top module: `alarm_set`

## Requirements
- R1: While `rst` is high at a rising clock edge, all six digit outputs become 0 at that edge.
- R2: A rising edge on `set_up` produces exactly one increment of each enabled field, however long `set_up` stays high. The new value appears at the second rising clock edge after `set_up` is first sampled high (with the default `SYNC_STAGES` = 2).
- R3: A field keeps its value when a `set_up` edge arrives while `alarm_mode` is low or while that field's select is low.
- R4: Seconds count in BCD. The ones digit goes 9 to 0 and carries into the tens digit, and 59 is followed by 00.
- R5: Minutes count in BCD. The ones digit goes 9 to 0 and carries into the tens digit, and 59 is followed by 00.
- R6: Hours count in BCD. 09 is followed by 10, 19 is followed by 20, and 23 is followed by 00.
- R7: A wrap of seconds never changes minutes, and a wrap of minutes never changes hours.
- R8: When several selects are high on one step, each selected field advances by exactly one, independently of the others.
- R9: Every digit output stays in its legal range. Ones digits stay in 0 to 9. The seconds tens and minutes tens digits stay in 0 to 5 with bit 3 at 0. The hours tens digit stays in 0 to 2 with bits 3:2 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| set_up | input | 1 | Manual set button (level); each rising edge is one step |
| alarm_mode | input | 1 | High while the user is editing the alarm time |
| sel_hours | input | 1 | Enables hour stepping |
| sel_minutes | input | 1 | Enables minute stepping |
| sel_seconds | input | 1 | Enables second stepping |
| hours_tens | output | 4 | Hours tens digit, BCD |
| hours_ones | output | 4 | Hours ones digit, BCD |
| minutes_tens | output | 4 | Minutes tens digit, BCD |
| minutes_ones | output | 4 | Minutes ones digit, BCD |
| seconds_tens | output | 4 | Seconds tens digit, BCD |
| seconds_ones | output | 4 | Seconds ones digit, BCD |

## Verification
A wrap in one field and an increment in its neighbour can fall on the same step. The bench provokes this by stepping the seconds field to 59 and then raising the seconds and minutes selects together for a single button press. The result is judged correct when seconds read 00 and minutes have advanced by exactly one, not by two. The same pairing is also exercised with minutes at 59 together with hours.

// File: rtl/alarm_set_pkg.sv
package alarm_set_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;

  // Field limits (largest legal value of each field)
  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;

  function automatic bcd_t tens_of(input int v);
    return bcd_t'(v / 10);
  endfunction

  function automatic bcd_t ones_of(input int v);
    return bcd_t'(v % 10);
  endfunction
endpackage

// File: rtl/alarm_up_sync.sv
// Brings the set button into the clock domain and emits a one-cycle
// step on each rising edge. STAGES must be at least 2.
module alarm_up_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic step
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], btn};
  end

  assign step = sr[LAST-1] & ~sr[LAST];
endmodule

// File: rtl/alarm_bcd_digit.sv
// One BCD digit counting 0..MODULUS-1 with a synchronous clear.
module alarm_bcd_digit
  import alarm_set_pkg::*;
#(
  parameter int MODULUS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output bcd_t value,
  output logic at_top
);
  localparam bcd_t TOP = bcd_t'(MODULUS - 1);

  bcd_t q;

  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (inc)    q <= (q == TOP) ? '0 : q + bcd_t'(1);
  end

  assign value  = q;
  assign at_top = (q == TOP);
endmodule

// File: rtl/alarm_time_field.sv
// Two-digit BCD field that wraps to 00 after LAST_VALUE.
module alarm_time_field
  import alarm_set_pkg::*;
#(
  parameter int TENS_MOD   = 6,
  parameter int LAST_VALUE = 59
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output bcd_t tens,
  output bcd_t ones
);
  localparam bcd_t LAST_T = tens_of(LAST_VALUE);
  localparam bcd_t LAST_O = ones_of(LAST_VALUE);

  logic wrap;
  logic ones_top;
  logic tens_top;

  assign wrap = step && (tens == LAST_T) && (ones == LAST_O);

  alarm_bcd_digit #(.MODULUS(10)) u_ones (
    .clk(clk), .rst(rst), .clr(wrap), .inc(step),
    .value(ones), .at_top(ones_top)
  );

  alarm_bcd_digit #(.MODULUS(TENS_MOD)) u_tens (
    .clk(clk), .rst(rst), .clr(wrap), .inc(step && ones_top),
    .value(tens), .at_top(tens_top)
  );

  logic unused_tens_top;
  assign unused_tens_top = tens_top;
endmodule

// File: rtl/alarm_set.sv
module alarm_set
  import alarm_set_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic set_up,
  input  logic alarm_mode,
  input  logic sel_hours,
  input  logic sel_minutes,
  input  logic sel_seconds,
  output logic [3:0] hours_tens,
  output logic [3:0] hours_ones,
  output logic [3:0] minutes_tens,
  output logic [3:0] minutes_ones,
  output logic [3:0] seconds_tens,
  output logic [3:0] seconds_ones
);
  logic up_step;

  alarm_up_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .btn(set_up), .step(up_step)
  );

  logic step_h, step_m, step_s;
  assign step_h = up_step && alarm_mode && sel_hours;
  assign step_m = up_step && alarm_mode && sel_minutes;
  assign step_s = up_step && alarm_mode && sel_seconds;

  alarm_time_field #(.TENS_MOD(3), .LAST_VALUE(HOUR_LAST)) u_hours (
    .clk(clk), .rst(rst), .step(step_h),
    .tens(hours_tens), .ones(hours_ones)
  );

  alarm_time_field #(.TENS_MOD(6), .LAST_VALUE(MIN_LAST)) u_minutes (
    .clk(clk), .rst(rst), .step(step_m),
    .tens(minutes_tens), .ones(minutes_ones)
  );

  alarm_time_field #(.TENS_MOD(6), .LAST_VALUE(SEC_LAST)) u_seconds (
    .clk(clk), .rst(rst), .step(step_s),
    .tens(seconds_tens), .ones(seconds_ones)
  );
endmodule

// File: rtl/alarm_set_chk.sv
module alarm_set_chk (
  input logic clk,
  input logic rst,
  input logic up_step,
  input logic alarm_mode,
  input logic sel_hours,
  input logic sel_minutes,
  input logic sel_seconds,
  input logic [3:0] hours_tens,
  input logic [3:0] hours_ones,
  input logic [3:0] minutes_tens,
  input logic [3:0] minutes_ones,
  input logic [3:0] seconds_tens,
  input logic [3:0] seconds_ones
);
  logic go_h, go_m, go_s;
  assign go_h = up_step && alarm_mode && sel_hours;
  assign go_m = up_step && alarm_mode && sel_minutes;
  assign go_s = up_step && alarm_mode && sel_seconds;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> ({hours_tens, hours_ones, minutes_tens, minutes_ones,
              seconds_tens, seconds_ones} == 24'h0));

  a_r9_digit_range: assert property (@(posedge clk) disable iff (rst)
    (hours_ones <= 4'd9) && (minutes_ones <= 4'd9) && (seconds_ones <= 4'd9) &&
    (hours_tens <= 4'd2) && (minutes_tens <= 4'd5) && (seconds_tens <= 4'd5));

  a_r3_hours_hold: assert property (@(posedge clk) disable iff (rst)
    !go_h |=> $stable({hours_tens, hours_ones}));
  a_r3_minutes_hold: assert property (@(posedge clk) disable iff (rst)
    !go_m |=> $stable({minutes_tens, minutes_ones}));
  a_r3_seconds_hold: assert property (@(posedge clk) disable iff (rst)
    !go_s |=> $stable({seconds_tens, seconds_ones}));

  a_r2_seconds_move: assert property (@(posedge clk) disable iff (rst)
    go_s |=> !$stable({seconds_tens, seconds_ones}));

  a_r4_seconds_wrap: assert property (@(posedge clk) disable iff (rst)
    (go_s && seconds_tens == 4'd5 && seconds_ones == 4'd9) |=>
    (seconds_tens == 4'd0 && seconds_ones == 4'd0));
  a_r5_minutes_wrap: assert property (@(posedge clk) disable iff (rst)
    (go_m && minutes_tens == 4'd5 && minutes_ones == 4'd9) |=>
    (minutes_tens == 4'd0 && minutes_ones == 4'd0));
  a_r6_hours_wrap: assert property (@(posedge clk) disable iff (rst)
    (go_h && hours_tens == 4'd2 && hours_ones == 4'd3) |=>
    (hours_tens == 4'd0 && hours_ones == 4'd0));

  a_r7_minutes_ignore_seconds: assert property (@(posedge clk) disable iff (rst)
    (go_s && !go_m) |=> $stable({minutes_tens, minutes_ones}));
endmodule

bind alarm_set alarm_set_chk u_chk (
  .clk(clk), .rst(rst), .up_step(up_step), .alarm_mode(alarm_mode),
  .sel_hours(sel_hours), .sel_minutes(sel_minutes), .sel_seconds(sel_seconds),
  .hours_tens(hours_tens), .hours_ones(hours_ones),
  .minutes_tens(minutes_tens), .minutes_ones(minutes_ones),
  .seconds_tens(seconds_tens), .seconds_ones(seconds_ones)
);

// File: tb/alarm_set_tb.sv
`timescale 1ns/1ps
module alarm_set_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_up = 1'b0;
  logic alarm_mode = 1'b0;
  logic sel_hours = 1'b0, sel_minutes = 1'b0, sel_seconds = 1'b0;
  logic [3:0] hours_tens, hours_ones, minutes_tens, minutes_ones;
  logic [3:0] seconds_tens, seconds_ones;

  always #2.5 clk = ~clk;

  alarm_set u_dut (
    .clk(clk), .rst(rst), .set_up(set_up), .alarm_mode(alarm_mode),
    .sel_hours(sel_hours), .sel_minutes(sel_minutes), .sel_seconds(sel_seconds),
    .hours_tens(hours_tens), .hours_ones(hours_ones),
    .minutes_tens(minutes_tens), .minutes_ones(minutes_ones),
    .seconds_tens(seconds_tens), .seconds_ones(seconds_ones)
  );

  typedef struct {
    logic [23:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  event  chk_ev;
  int    n_vec = 0;
  int    n_bad = 0;
  int    hh = 0, mm = 0, ss = 0;
  bit    done = 0;

  function automatic logic [23:0] pack_time(input int h, input int m, input int s);
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  task automatic expect_now(input string tag);
    item_t it;
    it.exp = pack_time(hh, mm, ss);
    it.tag = tag;
    sb.push_back(it);
    -> chk_ev;
  endtask

  // Driver: one button press of 'hold' cycles, model update, push expectation
  task automatic press(input bit m, input bit h, input bit mi, input bit s,
                       input int hold, input string tag);
    @(negedge clk);
    alarm_mode = m; sel_hours = h; sel_minutes = mi; sel_seconds = s;
    set_up = 1'b1;
    repeat (hold) @(negedge clk);
    set_up = 1'b0;
    repeat (3) @(negedge clk);
    if (m && s) ss = (ss + 1) % 60;
    if (m && mi) mm = (mm + 1) % 60;
    if (m && h) hh = (hh + 1) % 24;
    expect_now(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    hh = 0; mm = 0; ss = 0;
    expect_now(tag);
  endtask

  // Monitor
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [23:0] got;
        it  = sb.pop_front();
        got = {hours_tens, hours_ones, minutes_tens, minutes_ones,
               seconds_tens, seconds_ones};
        n_vec++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_now("R1 reset state");

    // R2: seconds stepping, and a long press counts once
    for (int i = 0; i < 5; i++) press(1, 0, 0, 1, 2, "R2 seconds step");
    press(1, 0, 0, 1, 12, "R2 long press counts once");

    // R3: mode low or select low leaves everything alone
    press(0, 1, 1, 1, 2, "R3 alarm mode low");
    press(1, 0, 0, 0, 2, "R3 no select");

    // R4 + R7: seconds run to 59 and wrap, minutes untouched
    while (ss != 59) press(1, 0, 0, 1, 2, "R4 seconds count");
    press(1, 0, 0, 1, 2, "R4 R7 seconds wrap 59->00");

    // R5 + R7: minutes run to 59 and wrap, hours untouched
    while (mm != 59) press(1, 0, 1, 0, 2, "R5 minutes count");
    press(1, 0, 1, 0, 2, "R5 R7 minutes wrap 59->00");

    // R6: hours through 09->10, 19->20, 23->00
    for (int i = 0; i < 24; i++) press(1, 1, 0, 0, 2, "R6 hours count");

    // R8: seconds wrap and minute step on the same press
    while (ss != 59) press(1, 0, 0, 1, 2, "R8 seconds setup");
    press(1, 0, 1, 1, 2, "R8 seconds wrap with minute step");
    while (mm != 59) press(1, 0, 1, 0, 2, "R8 minutes setup");
    press(1, 1, 1, 0, 2, "R8 minutes wrap with hour step");
    press(1, 1, 1, 1, 2, "R8 all three fields");

    do_reset("R1 reset mid-run");
    press(1, 1, 1, 1, 2, "R9 after reset all fields");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule